// File: doc/BRIEF.md
# Cursor-Addressed Pixel Access Unit

This unit sits between a host or drawing engine and a video memory. It keeps an X and a Y cursor and turns each pixel access into a memory request at the current cursor position. Each access carries an advance code, and that code alone decides which axis the cursors step along once the access has been issued. A control register sets the geometry. It chooses which axis is the major axis and the direction of travel on each axis. It also chooses whether the frame has 960 or 1024 lines.

Three access flavours exist. A plain access writes one pixel. A stippled access writes one pixel, but only when the top bit of an 8-bit rotating pattern register is 1; this lets patterned lines and fills be drawn without software masking. A wide access writes a run of 10 horizontally adjacent pixels in one request. Every write also presents a per-plane write mask, which the memory uses to protect planes. The memory array and display refresh sit outside this block.

Top module: `cpx_access`

## Requirements
- R1: After reset, both cursors are 0, `mem_req` and `mem_we` are 0, and `mem_mask` is all ones. The control register is 0, which gives X as the major axis, increment on both axes and 1024 lines. The stipple register is all ones.
- R2: An access sampled at a clock edge appears on the memory outputs after that same edge, for exactly one cycle. `mem_req` is 1 and `mem_x`/`mem_y` hold the cursor values from before the advance. `mem_data` equals `acc_data`, and `mem_we` equals `acc_write` for a plain access.
- R3: `acc_adv` codes: 0 leaves both cursors unchanged, 1 steps the major axis, 2 steps the minor axis, 3 steps both. Control bit 0 = 0 makes X the major axis; 1 makes Y the major axis. Cursors change only on an advance or a load.
- R4: Control bit 1 = 1 makes the major axis decrement; control bit 2 = 1 makes the minor axis decrement. A 0 in either bit means increment.
- R5: X wraps modulo 1280. Y wraps modulo L, where L is 960 when control bit 3 = 1 and 1024 otherwise. For a step s, an increment with p+s >= limit gives p+s-limit, and a decrement with p < s gives p+limit-s.
- R6: A stippled access (`acc_kind` = 1) still raises `mem_req`. It drives `mem_we` low whenever bit 7 of the stipple register is 0.
- R7: Every stippled access rotates the stipple register left by one (bit 7 moves into bit 0), whether it reads, writes or is suppressed. Plain and wide accesses leave the register unchanged.
- R8: A wide access (`acc_kind` = 2) raises `mem_wide`. It steps X by 10 when X is the major axis and the major axis advances. Every other cursor step is 1.
- R9: `mem_mask` always shows the write-mask register, and writing it (`cfg_sel` = 4) changes the mask of every later access.
- R10: `cfg_sel` codes: 0 control (bits 3:0), 1 X cursor, 2 Y cursor, 3 stipple (bits 7:0), 4 write mask. Other codes change nothing. A configuration write in the same cycle as an access takes effect at that edge, but the access still uses the old values. A cursor load overrides that cursor's advance, and a stipple load overrides the rotation.
- R11: `acc_kind` = 3 behaves exactly as a plain access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select for configuration write |
| cfg_wdata | input | XW | Configuration write value |
| acc_valid | input | 1 | Pixel access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_kind | input | 2 | 0 plain, 1 stippled, 2 wide, 3 as plain |
| acc_adv | input | 2 | Cursor advance code |
| acc_data | input | PLANES | Pixel value to write |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Memory write enable |
| mem_wide | output | 1 | Request covers 10 pixels from mem_x |
| mem_x | output | XW | Request X address |
| mem_y | output | YW | Request Y address |
| mem_data | output | PLANES | Request pixel value |
| mem_mask | output | PLANES | Per-plane write enable |
| cur_x | output | XW | Current X cursor |
| cur_y | output | YW | Current Y cursor |

## Verification
Every result of an access is due one edge after the access is sampled. The memory request fields carry the old cursor, and `cur_x`/`cur_y` carry the stepped cursor. Configuration writes are visible at the first access issued after their edge. The bench drives inputs at the falling edge and samples all outputs one time unit after the next rising edge. It also checks that `mem_req` drops on the following idle cycle. Random accesses are compared with a bench model that applies the wrap, stipple and wide-step rules. Directed cases cover both Y limits, wrap at both X ends, same-cycle load priority and unknown register selects.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

    // Advance code carried by every access
    typedef enum logic [1:0] {
        ADV_NONE = 2'd0,
        ADV_MAJ  = 2'd1,
        ADV_MIN  = 2'd2,
        ADV_BOTH = 2'd3
    } adv_e;

    // Access flavour
    typedef enum logic [1:0] {
        ACC_PLAIN = 2'd0,
        ACC_STIP  = 2'd1,
        ACC_WIDE  = 2'd2,
        ACC_RSVD  = 2'd3
    } kind_e;

    // Configuration register select
    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_XCUR  = 3'd1,
        REG_YCUR  = 3'd2,
        REG_STIP  = 3'd3,
        REG_WMASK = 3'd4
    } reg_e;

    // Geometry control: bit0 major_y, bit1 major_dec, bit2 minor_dec, bit3 short frame
    typedef struct packed {
        logic short_frame;
        logic minor_dec;
        logic major_dec;
        logic major_y;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Modular step of a position by 'step' inside [0, lim)
    function automatic logic [31:0] wrap_step(
        input logic [31:0] cur,
        input logic [31:0] step,
        input logic        dec,
        input logic [31:0] lim
    );
        logic [31:0] r;
        if (dec) begin
            r = (cur >= step) ? cur - step : cur + lim - step;
        end else begin
            r = (cur + step >= lim) ? cur + step - lim : cur + step;
        end
        return r;
    endfunction

    // Stipple rotate-left by one
    function automatic logic [7:0] rotl8(input logic [7:0] v);
        return {v[6:0], v[7]};
    endfunction

endpackage

// File: rtl/cpx_axis.sv
module cpx_axis #(
    parameter int W        = 11,
    parameter int BIG_STEP = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         adv,
    input  logic         dec,
    input  logic         big,
    input  logic [W:0]   lim,
    output logic [W-1:0] pos
);
    localparam logic [31:0] STEP_BIG = 32'(BIG_STEP);

    logic [31:0] step;
    logic [W-1:0] nxt;

    always_comb begin
        step = big ? STEP_BIG : 32'd1;
        nxt  = W'(cpx_pkg::wrap_step(32'(pos), step, dec, 32'(lim)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (load) begin
            pos <= load_val;
        end else if (adv) begin
            pos <= nxt;
        end
    end

    // An in-range position stays in range after a step
    AST_AXIS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && ({1'b0, pos} < lim)) |=> ({1'b0, pos} < $past(lim))) // R5
        else $error("axis left its range");

    // Without advance or load the position holds
    AST_AXIS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> $stable(pos)) // R3
        else $error("axis moved without advance");

    // A load always wins over an advance
    AST_AXIS_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load |=> (pos == $past(load_val))) // R10
        else $error("load did not take priority");

endmodule

// File: rtl/cpx_regs.sv
module cpx_regs #(
    parameter int PLANES = 8,
    parameter int STIP_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_ctrl,
    input  logic                  wr_stip,
    input  logic                  wr_mask,
    input  cpx_pkg::ctrl_t        ctrl_val,
    input  logic [STIP_W-1:0]     stip_val,
    input  logic [PLANES-1:0]     mask_val,
    input  logic                  rotate,
    output cpx_pkg::ctrl_t        ctrl,
    output logic [PLANES-1:0]     wmask,
    output logic                  gate
);
    logic [STIP_W-1:0] stip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            wmask  <= '1;
            stip_q <= '1;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_val;
            if (wr_mask) wmask <= mask_val;
            if (wr_stip) begin
                stip_q <= stip_val;
            end else if (rotate) begin
                stip_q <= {stip_q[STIP_W-2:0], stip_q[STIP_W-1]};
            end
        end
    end

    assign gate = stip_q[STIP_W-1];

    // Stippled access rotates the pattern left by one
    AST_STIP_ROTATE: assert property (@(posedge clk) disable iff (rst)
        (rotate && !wr_stip) |=>
        (stip_q == {$past(stip_q[STIP_W-2:0]), $past(stip_q[STIP_W-1])})) // R7
        else $error("stipple did not rotate");

    // No rotation and no write keeps the pattern
    AST_STIP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rotate && !wr_stip) |=> $stable(stip_q)) // R7
        else $error("stipple changed without cause");

endmodule

// File: rtl/cpx_issue.sv
module cpx_issue #(
    parameter int PLANES = 8,
    parameter int XW     = 11,
    parameter int YW     = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              wr,
    input  cpx_pkg::kind_e    kind,
    input  logic              gate,
    input  logic [XW-1:0]     x,
    input  logic [YW-1:0]     y,
    input  logic [PLANES-1:0] data,
    input  logic [PLANES-1:0] mask,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [XW-1:0]     mem_x,
    output logic [YW-1:0]     mem_y,
    output logic [PLANES-1:0] mem_data,
    output logic [PLANES-1:0] mem_mask
);
    import cpx_pkg::*;

    logic suppress;

    always_comb begin
        suppress = (kind == ACC_STIP) && !gate;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req  <= 1'b0;
            mem_we   <= 1'b0;
            mem_wide <= 1'b0;
            mem_x    <= '0;
            mem_y    <= '0;
            mem_data <= '0;
        end else begin
            mem_req  <= fire;
            mem_we   <= fire && wr && !suppress;
            mem_wide <= fire && (kind == ACC_WIDE);
            if (fire) begin
                mem_x    <= x;
                mem_y    <= y;
                mem_data <= data;
            end
        end
    end

    assign mem_mask = mask;

    // Every access yields a request on the next cycle
    AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        fire |=> mem_req) // R2
        else $error("access lost");

    // Request address is the cursor value at the access edge
    AST_ADDR_OLD: assert property (@(posedge clk) disable iff (rst)
        fire |=> (mem_x == $past(x) && mem_y == $past(y))) // R2
        else $error("address not pre-advance cursor");

    // A gated stippled access never writes
    AST_NO_GATED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (fire && kind == ACC_STIP && !gate) |=> !mem_we) // R6
        else $error("stipple gate ignored");

    // A write enable only follows a write access
    AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req) // R2
        else $error("write without request");

endmodule

// File: rtl/cpx_access.sv
module cpx_access #(
    parameter int PLANES   = 8,
    parameter int XW       = 11,
    parameter int YW       = 10,
    parameter int X_SPAN   = 1280,
    parameter int Y_TALL   = 1024,
    parameter int Y_SHORT  = 960,
    parameter int WIDE_PIX = 10,
    parameter int STIP_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [XW-1:0]     cfg_wdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        acc_adv,
    input  logic [PLANES-1:0] acc_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [XW-1:0]     mem_x,
    output logic [YW-1:0]     mem_y,
    output logic [PLANES-1:0] mem_data,
    output logic [PLANES-1:0] mem_mask,
    output logic [XW-1:0]     cur_x,
    output logic [YW-1:0]     cur_y
);
    import cpx_pkg::*;

    // Configuration values are taken from the low bits of cfg_wdata;
    // PLANES, STIP_W, YW and CTRL_W must not exceed XW.
    localparam logic [XW:0] X_LIM     = (XW + 1)'(X_SPAN);
    localparam logic [YW:0] Y_LIM_T   = (YW + 1)'(Y_TALL);
    localparam logic [YW:0] Y_LIM_S   = (YW + 1)'(Y_SHORT);

    kind_e  kind;
    adv_e   adv;
    reg_e   sel;
    ctrl_t  ctrl;
    logic [PLANES-1:0] wmask;
    logic   gate;

    logic   maj_go, min_go;
    logic   x_adv, y_adv, x_dec, y_dec, x_big;
    logic   ld_x, ld_y, wr_ctrl, wr_stip, wr_mask;
    logic [YW:0] y_lim;

    always_comb begin
        kind = kind_e'(acc_kind);
        adv  = adv_e'(acc_adv);
        sel  = reg_e'(cfg_sel);

        wr_ctrl = cfg_we && (sel == REG_CTRL);
        ld_x    = cfg_we && (sel == REG_XCUR);
        ld_y    = cfg_we && (sel == REG_YCUR);
        wr_stip = cfg_we && (sel == REG_STIP);
        wr_mask = cfg_we && (sel == REG_WMASK);

        maj_go = acc_valid && (adv == ADV_MAJ || adv == ADV_BOTH);
        min_go = acc_valid && (adv == ADV_MIN || adv == ADV_BOTH);

        x_adv = ctrl.major_y ? min_go : maj_go;
        y_adv = ctrl.major_y ? maj_go : min_go;
        x_dec = ctrl.major_y ? ctrl.minor_dec : ctrl.major_dec;
        y_dec = ctrl.major_y ? ctrl.major_dec : ctrl.minor_dec;
        x_big = (kind == ACC_WIDE) && !ctrl.major_y && maj_go;

        y_lim = ctrl.short_frame ? Y_LIM_S : Y_LIM_T;
    end

    cpx_regs #(
        .PLANES(PLANES),
        .STIP_W(STIP_W)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_ctrl),
        .wr_stip  (wr_stip),
        .wr_mask  (wr_mask),
        .ctrl_val (ctrl_t'(cfg_wdata[CTRL_W-1:0])),
        .stip_val (cfg_wdata[STIP_W-1:0]),
        .mask_val (cfg_wdata[PLANES-1:0]),
        .rotate   (acc_valid && kind == ACC_STIP),
        .ctrl     (ctrl),
        .wmask    (wmask),
        .gate     (gate)
    );

    cpx_axis #(
        .W        (XW),
        .BIG_STEP (WIDE_PIX)
    ) x_axis_i (
        .clk      (clk),
        .rst      (rst),
        .load     (ld_x),
        .load_val (cfg_wdata),
        .adv      (x_adv),
        .dec      (x_dec),
        .big      (x_big),
        .lim      (X_LIM),
        .pos      (cur_x)
    );

    cpx_axis #(
        .W        (YW),
        .BIG_STEP (1)
    ) y_axis_i (
        .clk      (clk),
        .rst      (rst),
        .load     (ld_y),
        .load_val (cfg_wdata[YW-1:0]),
        .adv      (y_adv),
        .dec      (y_dec),
        .big      (1'b0),
        .lim      (y_lim),
        .pos      (cur_y)
    );

    cpx_issue #(
        .PLANES (PLANES),
        .XW     (XW),
        .YW     (YW)
    ) issue_i (
        .clk      (clk),
        .rst      (rst),
        .fire     (acc_valid),
        .wr       (acc_write),
        .kind     (kind),
        .gate     (gate),
        .x        (cur_x),
        .y        (cur_y),
        .data     (acc_data),
        .mask     (wmask),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_wide (mem_wide),
        .mem_x    (mem_x),
        .mem_y    (mem_y),
        .mem_data (mem_data),
        .mem_mask (mem_mask)
    );

    // A wide major step on X moves it by the run length
    AST_WIDE_STEP: assert property (@(posedge clk) disable iff (rst)
        (x_big && !ld_x && !x_dec && ({1'b0, cur_x} + (XW + 1)'(WIDE_PIX) < X_LIM))
        |=> (cur_x == $past(cur_x) + XW'(WIDE_PIX))) // R8
        else $error("wide step wrong");

    // Idle cycle with no cursor load keeps both cursors
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid && !cfg_we) |=> ($stable(cur_x) && $stable(cur_y))) // R3
        else $error("cursor drifted while idle");

endmodule

// File: tb/cpx_access_tb.sv
module cpx_access_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [10:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [1:0]  acc_adv = '0;
    logic [7:0]  acc_data = '0;
    logic        mem_req, mem_we, mem_wide;
    logic [10:0] mem_x, cur_x;
    logic [9:0]  mem_y, cur_y;
    logic [7:0]  mem_data, mem_mask;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Bench model state
    int unsigned m_x, m_y;
    logic [3:0]  m_ctrl;
    logic [7:0]  m_stip, m_mask;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cpx_access dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_kind(acc_kind), .acc_adv(acc_adv), .acc_data(acc_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_x(mem_x), .mem_y(mem_y), .mem_data(mem_data),
        .mem_mask(mem_mask), .cur_x(cur_x), .cur_y(cur_y)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int unsigned mstep(int unsigned p, int unsigned s, bit dec, int unsigned lim);
        if (dec) return (p < s) ? p + lim - s : p - s;
        return (p + s >= lim) ? p + s - lim : p + s;
    endfunction

    function automatic void model_cfg(input logic [2:0] sel, input logic [10:0] v);
        case (sel)
            3'd0: m_ctrl = v[3:0];
            3'd1: m_x = v;
            3'd2: m_y = v[9:0];
            3'd3: m_stip = v[7:0];
            3'd4: m_mask = v[7:0];
            default: ;
        endcase
    endfunction

    // Access, optionally with a same-cycle configuration write
    task automatic access_cfg(input logic [1:0] kind, input logic [1:0] adv, input bit wr,
                              input logic [7:0] data, input bit do_cfg,
                              input logic [2:0] sel, input logic [10:0] v, input string req);
        int unsigned ex_x, ex_y, ylim, xs;
        bit majy, ma, mi, xa, ya, xd, yd, ex_we;
        ex_x = m_x; ex_y = m_y;
        majy = m_ctrl[0]; ma = adv[0]; mi = adv[1];
        xa = majy ? mi : ma;  ya = majy ? ma : mi;
        xd = majy ? m_ctrl[2] : m_ctrl[1];
        yd = majy ? m_ctrl[1] : m_ctrl[2];
        xs = (kind == 2'd2 && !majy && ma) ? 10 : 1;
        ylim = m_ctrl[3] ? 960 : 1024;
        ex_we = wr && !(kind == 2'd1 && !m_stip[7]);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = kind; acc_adv = adv; acc_write = wr; acc_data = data;
        cfg_we = do_cfg; cfg_sel = sel; cfg_wdata = v;
        @(posedge clk);
        #1;
        acc_valid = 1'b0; cfg_we = 1'b0;
        check({req, " req"}, 32'(mem_req), 32'd1);
        check({req, " we"}, 32'(mem_we), 32'(ex_we));
        check({req, " wide"}, 32'(mem_wide), 32'(kind == 2'd2));
        check({req, " mx"}, 32'(mem_x), ex_x);
        check({req, " my"}, 32'(mem_y), ex_y);
        check({req, " data"}, 32'(mem_data), 32'(data));
        check({req, " mask"}, 32'(mem_mask), 32'(m_mask));
        if (xa) m_x = mstep(m_x, xs, xd, 1280);
        if (ya) m_y = mstep(m_y, 1, yd, ylim);
        if (kind == 2'd1) m_stip = {m_stip[6:0], m_stip[7]};
        if (do_cfg) model_cfg(sel, v);
        check({req, " cx"}, 32'(cur_x), m_x);
        check({req, " cy"}, 32'(cur_y), m_y);
    endtask

    task automatic access(input logic [1:0] kind, input logic [1:0] adv, input bit wr,
                          input logic [7:0] data, input string req);
        access_cfg(kind, adv, wr, data, 1'b0, 3'd0, 11'd0, req);
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [10:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        model_cfg(sel, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1985));
        m_x = 0; m_y = 0; m_ctrl = '0; m_stip = 8'hFF; m_mask = 8'hFF;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 cur_x", 32'(cur_x), 0);
        check("R1 cur_y", 32'(cur_y), 0);
        check("R1 req", 32'(mem_req), 0);
        check("R1 we", 32'(mem_we), 0);
        check("R1 mask", 32'(mem_mask), 32'hFF);

        // R1/R6 stipple starts all ones: first stippled write goes through
        access(2'd1, 2'd0, 1'b1, 8'h5A, "R1 stip reset");
        // R2 request lasts one cycle
        @(posedge clk); #1;
        check("R2 req drop", 32'(mem_req), 0);

        // R3 advance codes with X major
        access(2'd0, 2'd1, 1'b1, 8'h01, "R3 major x");
        access(2'd0, 2'd2, 1'b1, 8'h02, "R3 minor y");
        access(2'd0, 2'd3, 1'b0, 8'h03, "R3 both");
        access(2'd0, 2'd0, 1'b1, 8'h04, "R3 none");
        cfg(3'd0, 11'b0001);                   // Y major
        access(2'd0, 2'd1, 1'b1, 8'h05, "R3 major y");
        access(2'd0, 2'd2, 1'b1, 8'h06, "R3 minor x");

        // R4 and R5: decrement wrap at 0, increment wrap at 1279
        cfg(3'd0, 11'b0110);                   // X major, both decrement
        cfg(3'd1, 11'd0); cfg(3'd2, 11'd0);
        access(2'd0, 2'd3, 1'b1, 8'h07, "R4 R5 dec wrap");
        cfg(3'd0, 11'b0000);
        cfg(3'd1, 11'd1279);
        access(2'd0, 2'd1, 1'b1, 8'h08, "R5 x inc wrap");
        // R5 960 and 1024 line limits
        cfg(3'd0, 11'b1001);                   // short frame, Y major
        cfg(3'd2, 11'd959);
        access(2'd0, 2'd1, 1'b1, 8'h09, "R5 y960 wrap");
        cfg(3'd0, 11'b0001);
        cfg(3'd2, 11'd1023);
        access(2'd0, 2'd1, 1'b1, 8'h0A, "R5 y1024 wrap");
        cfg(3'd2, 11'd959);
        access(2'd0, 2'd1, 1'b1, 8'h0B, "R5 y no wrap at 960 tall");

        // R6/R7 stipple pattern over more than 8 steps, reads included
        cfg(3'd0, 11'b0000);
        cfg(3'd3, 11'b1010_0110);
        for (int i = 0; i < 10; i++) access(2'd1, 2'd1, (i != 3), 8'h20, "R6 R7 stipple");
        // R7 plain and wide do not rotate
        access(2'd0, 2'd0, 1'b1, 8'h21, "R7 plain keep");
        access(2'd2, 2'd0, 1'b1, 8'h22, "R7 wide keep");
        access(2'd1, 2'd0, 1'b1, 8'h23, "R7 after keep");

        // R8 wide steps
        cfg(3'd1, 11'd1275);
        access(2'd2, 2'd1, 1'b1, 8'h30, "R8 wide major wrap");
        access(2'd2, 2'd3, 1'b1, 8'h31, "R8 wide both");
        cfg(3'd0, 11'b0001);                   // Y major: X is minor, step 1
        access(2'd2, 2'd3, 1'b1, 8'h32, "R8 wide minor x");

        // R9 write mask
        cfg(3'd4, 11'h0C3);
        access(2'd0, 2'd0, 1'b1, 8'h40, "R9 mask");

        // R10 same-cycle load priority and ignored selects
        access_cfg(2'd0, 2'd3, 1'b1, 8'h50, 1'b1, 3'd1, 11'd100, "R10 x load wins");
        access_cfg(2'd1, 2'd0, 1'b1, 8'h51, 1'b1, 3'd3, 11'h00F, "R10 stip load wins");
        access(2'd1, 2'd0, 1'b1, 8'h52, "R10 stip after load");
        cfg(3'd5, 11'h7FF); cfg(3'd6, 11'h7FF); cfg(3'd7, 11'h7FF);
        access(2'd0, 2'd3, 1'b1, 8'h53, "R10 unknown sel");

        // R11 reserved kind acts as plain
        cfg(3'd3, 11'h000);
        access(2'd3, 2'd1, 1'b1, 8'h60, "R11 kind3");
        access(2'd1, 2'd0, 1'b1, 8'h61, "R11 no rotate");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            r = $urandom_range(0, 99);
            if (r < 8) cfg(3'd0, 11'($urandom_range(0, 15)));
            else if (r < 12) cfg(3'd1, 11'($urandom_range(0, 1279)));
            else if (r < 16) cfg(3'd2, 11'($urandom_range(0, 959)));
            else if (r < 20) cfg(3'd3, 11'($urandom_range(0, 255)));
            else if (r < 23) cfg(3'd4, 11'($urandom_range(0, 255)));
            else access(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                        1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
                        "R2 R3 R4 R5 R6 R8 random");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule